// File: doc/BRIEF.md
# Per-Block Read Threshold Shift Table

This block holds read-voltage corrections for every erase block of a two-bit-per-cell flash array. Each block has three read thresholds. Each threshold's correction is kept as two signed parts. The long-lived base part follows permanent wear, such as accumulated program/erase cycling. The short-lived delta part follows effects that an erase removes, such as charge loss during retention and read disturb. A host lookup gives a block address and a sensed cell voltage. One clock later the block returns the three effective thresholds and the two-bit value of that cell. Each effective threshold is the nominal level plus the base part plus the delta part, clamped to the 8-bit range.

A background calibrator writes single shift values through a separate port. It picks either the base set or the delta set, and one of the three thresholds. An event port reports erases. An erase clears the three delta parts of that block and leaves its base parts as they are. Lookups have no handshake, so calibration traffic can never hold them back.

Top module: `vst_shift_table`

## Requirements
- R1: `thrEff[8k+7:8k]` (k = 0, 1, 2) equals nominal k + base shift k + delta shift k of the block presented on `lkpBlock` in the previous cycle. Nominals default to 40, 120 and 230, and the shifts are 6-bit two's complement.
- R2: A sum below 0 gives 0 and a sum above 255 gives 255. The output never wraps.
- R3: `stateCode` classifies the `lkpSense` of the previous cycle against the effective thresholds t0 < t1 < t2 being output. Below t0 gives 2'b11, t0 up to but not including t1 gives 2'b01, t1 up to but not including t2 gives 2'b00, and t2 or above gives 2'b10.
- R4: A calibration write with `calSelDelta`=0 stores `calValue` into the base shift, and with `calSelDelta`=1 into the delta shift. The threshold chosen is `calIdx` (0..2) of block `calBlock`. A write with `calIdx`=3 changes nothing.
- R5: A lookup in the same cycle as a calibration write to the same block returns the old value. A lookup in the next cycle returns the new value. Lookups are accepted every cycle without a stall.
- R6: `evtErase` clears the three delta shifts of `evtBlock` to zero and keeps its base shifts.
- R7: An erase and a delta write to the same block in the same cycle leave that delta at zero. A base write in the same cycle as an erase of its block still takes effect.
- R8: While `rstN` is low, `thrEff` is 0 and `stateCode` is 2'b10. After reset every shift is zero, so lookups return the nominal levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lkpBlock | input | 6 | Block address for the host lookup |
| lkpSense | input | 8 | Sensed cell voltage to classify |
| calValid | input | 1 | Calibration write strobe |
| calSelDelta | input | 1 | 0 selects the base set, 1 selects the delta set |
| calIdx | input | 2 | Threshold index 0..2 (3 is ignored) |
| calBlock | input | 6 | Block address for the calibration write |
| calValue | input | 6 | Signed shift value to store |
| evtErase | input | 1 | Erase event strobe |
| evtBlock | input | 6 | Block address of the erase |
| thrEff | output | 24 | Three effective thresholds, threshold k at bits 8k+7:8k |
| stateCode | output | 2 | Two-bit value of the sensed cell |

## Verification
The assertions check four things on every cycle. The state code must agree with the thresholds being output and the sensed voltage of the previous cycle. An erase must leave the erased block's delta entries at zero and its base entries unchanged. A write with index 3 must leave both tables unchanged. The output must stay the same when the lookup is repeated and no write happened. Only the bench's scenarios can show that the sums are correct and saturate at both ends, because that needs a reference model. The same holds for the old-then-new ordering of a lookup that collides with a write, and for the erase/delta-write collision seen from the lookup port.

// File: rtl/vst_pkg.sv
package vst_pkg;
  localparam int NUM_BLOCKS = 64;
  localparam int BLK_W      = $clog2(NUM_BLOCKS);
  localparam int VOLT_W     = 8;
  localparam int SHIFT_W    = 6;
  localparam int NUM_THR    = 3;
  localparam int IDX_W      = 2;

  typedef logic [NUM_BLOCKS-1:0][NUM_THR-1:0][SHIFT_W-1:0] shiftTab_t;

  // strobes from control to datapath
  typedef struct packed {
    logic               wrBase;
    logic               wrDelta;
    logic               clrDelta;
    logic [BLK_W-1:0]   wrBlock;
    logic [IDX_W-1:0]   wrIdx;
    logic [SHIFT_W-1:0] wrVal;
    logic [BLK_W-1:0]   clrBlock;
  } tblCtrl_t;
endpackage

// File: rtl/vst_ctrl.sv
module vst_ctrl
  import vst_pkg::*;
(
  input  logic               calValid,
  input  logic               calSelDelta,
  input  logic [IDX_W-1:0]   calIdx,
  input  logic [BLK_W-1:0]   calBlock,
  input  logic [SHIFT_W-1:0] calValue,
  input  logic               evtErase,
  input  logic [BLK_W-1:0]   evtBlock,
  output tblCtrl_t           ctrl
);
  logic idxOk;
  logic eraseHit;

  always_comb begin
    idxOk         = (32'(calIdx) < NUM_THR);
    eraseHit      = evtErase && (evtBlock == calBlock);
    ctrl.wrBase   = calValid && idxOk && !calSelDelta;
    // an erase of the same block overrides a delta update
    ctrl.wrDelta  = calValid && idxOk && calSelDelta && !eraseHit;
    ctrl.clrDelta = evtErase;
    ctrl.wrBlock  = calBlock;
    ctrl.wrIdx    = calIdx;
    ctrl.wrVal    = calValue;
    ctrl.clrBlock = evtBlock;
  end
endmodule

// File: rtl/vst_datapath.sv
module vst_datapath
  import vst_pkg::*;
#(
  parameter logic [NUM_THR*VOLT_W-1:0] NOMINALS = {8'd230, 8'd120, 8'd40}
)(
  input  logic                      clk,
  input  logic                      rstN,
  input  tblCtrl_t                  ctrl,
  input  logic [BLK_W-1:0]          lkpBlock,
  input  logic [VOLT_W-1:0]         lkpSense,
  output logic [NUM_THR*VOLT_W-1:0] thrEff,
  output logic [1:0]                stateCode,
  output shiftTab_t                 baseTab,
  output shiftTab_t                 deltaTab
);
  localparam int SUM_W = VOLT_W + 2;
  localparam int EXT_W = SUM_W - SHIFT_W;
  localparam logic [VOLT_W-1:0] VMAX = {VOLT_W{1'b1}};

  logic [NUM_THR-1:0][VOLT_W-1:0] effNext;
  logic [1:0]                     codeNext;

  // shift storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseTab  <= '0;
      deltaTab <= '0;
    end else begin
      if (ctrl.wrBase)
        baseTab[ctrl.wrBlock][ctrl.wrIdx] <= ctrl.wrVal;
      if (ctrl.wrDelta)
        deltaTab[ctrl.wrBlock][ctrl.wrIdx] <= ctrl.wrVal;
      if (ctrl.clrDelta)
        deltaTab[ctrl.clrBlock] <= '0;
    end
  end

  // per-threshold saturating adders
  for (genvar t = 0; t < NUM_THR; t++) begin : gSum
    logic [SHIFT_W-1:0] bVal;
    logic [SHIFT_W-1:0] dVal;
    logic [SUM_W-1:0]   sum;
    always_comb begin
      bVal = baseTab[lkpBlock][t];
      dVal = deltaTab[lkpBlock][t];
      sum  = {2'b00, NOMINALS[t*VOLT_W +: VOLT_W]}
           + {{EXT_W{bVal[SHIFT_W-1]}}, bVal}
           + {{EXT_W{dVal[SHIFT_W-1]}}, dVal};
      if (sum[SUM_W-1])
        effNext[t] = '0;
      else if (sum[VOLT_W])
        effNext[t] = VMAX;
      else
        effNext[t] = sum[VOLT_W-1:0];
    end
  end

  // cell state classifier, thresholds in increasing order
  always_comb begin
    if (lkpSense < effNext[0])      codeNext = 2'b11;
    else if (lkpSense < effNext[1]) codeNext = 2'b01;
    else if (lkpSense < effNext[2]) codeNext = 2'b00;
    else                            codeNext = 2'b10;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      thrEff    <= '0;
      stateCode <= 2'b10;
    end else begin
      thrEff    <= effNext;
      stateCode <= codeNext;
    end
  end
endmodule

// File: rtl/vst_shift_table.sv
module vst_shift_table
  import vst_pkg::*;
#(
  parameter logic [NUM_THR*VOLT_W-1:0] NOMINALS = {8'd230, 8'd120, 8'd40}
)(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [BLK_W-1:0]          lkpBlock,
  input  logic [VOLT_W-1:0]         lkpSense,
  input  logic                      calValid,
  input  logic                      calSelDelta,
  input  logic [IDX_W-1:0]          calIdx,
  input  logic [BLK_W-1:0]          calBlock,
  input  logic [SHIFT_W-1:0]        calValue,
  input  logic                      evtErase,
  input  logic [BLK_W-1:0]          evtBlock,
  output logic [NUM_THR*VOLT_W-1:0] thrEff,
  output logic [1:0]                stateCode
);
  tblCtrl_t  ctrl;
  shiftTab_t baseTab;
  shiftTab_t deltaTab;

  vst_ctrl uCtrl (
    .calValid    (calValid),
    .calSelDelta (calSelDelta),
    .calIdx      (calIdx),
    .calBlock    (calBlock),
    .calValue    (calValue),
    .evtErase    (evtErase),
    .evtBlock    (evtBlock),
    .ctrl        (ctrl)
  );

  vst_datapath #(.NOMINALS(NOMINALS)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .lkpBlock  (lkpBlock),
    .lkpSense  (lkpSense),
    .thrEff    (thrEff),
    .stateCode (stateCode),
    .baseTab   (baseTab),
    .deltaTab  (deltaTab)
  );
endmodule

// File: rtl/vst_checker.sv
module vst_checker
  import vst_pkg::*;
(
  input logic                      clk,
  input logic                      rstN,
  input logic [BLK_W-1:0]          lkpBlock,
  input logic [VOLT_W-1:0]         lkpSense,
  input logic                      calValid,
  input logic                      calSelDelta,
  input logic [IDX_W-1:0]          calIdx,
  input logic [BLK_W-1:0]          calBlock,
  input logic                      evtErase,
  input logic [BLK_W-1:0]          evtBlock,
  input logic [NUM_THR*VOLT_W-1:0] thrEff,
  input logic [1:0]                stateCode,
  input shiftTab_t                 baseTab,
  input shiftTab_t                 deltaTab
);
  function automatic logic [1:0] classOf(input logic [VOLT_W-1:0] v,
                                         input logic [NUM_THR*VOLT_W-1:0] th);
    if (v < th[0 +: VOLT_W])               return 2'b11;
    else if (v < th[VOLT_W +: VOLT_W])     return 2'b01;
    else if (v < th[2*VOLT_W +: VOLT_W])   return 2'b00;
    else                                   return 2'b10;
  endfunction

  // R3
  state_class_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (stateCode == classOf($past(lkpSense), thrEff)));

  // R6
  erase_clears_delta_chk: assert property (@(posedge clk) disable iff (!rstN)
    evtErase |=> (deltaTab[$past(evtBlock)] == '0));

  // R6
  erase_keeps_base_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtErase && !(calValid && !calSelDelta && calBlock == evtBlock))
      |=> (baseTab[$past(evtBlock)] == $past(baseTab[evtBlock])));

  // R4
  bad_index_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (calValid && calIdx == 2'd3 && !evtErase) |=> ($stable(baseTab) && $stable(deltaTab)));

  // R1
  repeat_lookup_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(rstN, 2) && lkpBlock == $past(lkpBlock) && lkpSense == $past(lkpSense)
      && !$past(calValid) && !$past(evtErase)) |=> ($stable(thrEff) && $stable(stateCode)));
endmodule

bind vst_shift_table vst_checker chk (.*);

// File: tb/vst_shift_table_test.sv
`timescale 1ns/1ps
module vst_shift_table_test;
  localparam int NB = 64;
  localparam int NOM [3] = '{40, 120, 230};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  lkpBlock = '0;
  logic [7:0]  lkpSense = '0;
  logic        calValid = 1'b0;
  logic        calSelDelta = 1'b0;
  logic [1:0]  calIdx = '0;
  logic [5:0]  calBlock = '0;
  logic [5:0]  calValue = '0;
  logic        evtErase = 1'b0;
  logic [5:0]  evtBlock = '0;
  logic [23:0] thrEff;
  logic [1:0]  stateCode;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  int refB [NB][3];
  int refD [NB][3];
  bit pend = 0;
  logic [23:0] expThr;
  logic [1:0]  expCode;
  string pendTag;

  always #10 clk = ~clk;

  vst_shift_table uut (.*);

  function automatic int satAdd(input int a, input int b, input int c);
    int s = a + b + c;
    if (s < 0) return 0;
    if (s > 255) return 255;
    return s;
  endfunction

  function automatic logic [1:0] cls(input int v, input logic [23:0] th);
    if (v < int'(th[7:0]))   return 2'b11;
    if (v < int'(th[15:8]))  return 2'b01;
    if (v < int'(th[23:16])) return 2'b00;
    return 2'b10;
  endfunction

  task automatic check(input string tag, input logic [25:0] act, input logic [25:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input int blk, input int sense, input bit cv, input bit csd,
                      input int cidx, input int cblk, input int cval,
                      input bit ev, input int eblk, input string tag);
    @(negedge clk);
    if (pend) check(pendTag, {stateCode, thrEff}, {expCode, expThr});
    lkpBlock = 6'(blk); lkpSense = 8'(sense);
    calValid = cv; calSelDelta = csd; calIdx = 2'(cidx);
    calBlock = 6'(cblk); calValue = 6'(cval);
    evtErase = ev; evtBlock = 6'(eblk);
    for (int k = 0; k < 3; k++)
      expThr[8*k +: 8] = 8'(satAdd(NOM[k], refB[blk][k], refD[blk][k]));
    expCode = cls(sense, expThr);
    if (cv && cidx < 3) begin
      if (!csd) refB[cblk][cidx] = int'($signed(6'(cval)));
      else if (!(ev && eblk == cblk)) refD[cblk][cidx] = int'($signed(6'(cval)));
    end
    if (ev) for (int k = 0; k < 3; k++) refD[eblk][k] = 0;
    pend = 1; pendTag = tag;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20.0 * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    for (int b = 0; b < NB; b++)
      for (int k = 0; k < 3; k++) begin refB[b][k] = 0; refD[b][k] = 0; end
    repeat (3) @(negedge clk);
    // R8 outputs held during reset
    check("R8 reset outputs", {stateCode, thrEff}, {2'b10, 24'h0});
    rstN = 1'b1;
    // R8 nominal levels after reset
    step(5, 0, 0, 0, 0, 0, 0, 0, 0, "R8 nominal after reset");
    // R2 high saturation, R5 old then new on collision
    step(2, 0, 1, 0, 2, 2, 31, 0, 0, "R4 base write");
    step(2, 0, 1, 1, 2, 2, 31, 0, 0, "R5 lookup sees old value");
    step(2, 250, 0, 0, 0, 0, 0, 0, 0, "R2 R5 saturate high after write");
    // R2 low saturation
    step(3, 0, 1, 0, 0, 3, -32, 0, 0, "R4 base neg");
    step(3, 0, 1, 1, 0, 3, -32, 0, 0, "R4 delta neg");
    step(3, 0, 0, 0, 0, 0, 0, 0, 0, "R2 saturate low");
    // R4 index 3 ignored
    step(4, 0, 1, 0, 3, 4, 17, 0, 0, "R4 idx3 write");
    step(4, 0, 1, 1, 3, 4, 9, 0, 0, "R4 idx3 write delta");
    step(4, 0, 0, 0, 0, 0, 0, 0, 0, "R4 idx3 no effect");
    // R6 / R7 erase with delta collision
    step(6, 0, 1, 0, 1, 6, 10, 0, 0, "R4 base idx1");
    step(6, 0, 1, 1, 1, 6, 5, 0, 0, "R4 delta idx1");
    step(6, 0, 1, 1, 1, 6, 7, 1, 6, "R1 value before erase");
    step(6, 0, 1, 0, 0, 6, 3, 1, 6, "R6 R7 erase wins over delta");
    step(6, 0, 0, 0, 0, 0, 0, 0, 0, "R7 base write with erase kept");
    // R3 classification boundaries
    step(5, 39, 0, 0, 0, 0, 0, 0, 0, "R3 below t0");
    step(5, 40, 0, 0, 0, 0, 0, 0, 0, "R3 at t0");
    step(5, 119, 0, 0, 0, 0, 0, 0, 0, "R3 below t1");
    step(5, 120, 0, 0, 0, 0, 0, 0, 0, "R3 at t1");
    step(5, 229, 0, 0, 0, 0, 0, 0, 0, "R3 below t2");
    step(5, 230, 0, 0, 0, 0, 0, 0, 0, "R3 at t2");
    // random traffic on a few blocks, R1 R3 R5 R6 R7
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4000; i++) begin
      step($urandom_range(0, 7), $urandom_range(0, 255),
           ($urandom_range(0, 3) != 0), $urandom_range(0, 1),
           $urandom_range(0, 3), $urandom_range(0, 7),
           $urandom_range(0, 63) - 32,
           ($urandom_range(0, 15) == 0), $urandom_range(0, 7),
           "R1 R3 R5 random");
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R1 flush");
    @(negedge clk);
    check("R1 final", {stateCode, thrEff}, {expCode, expThr});
    finishRun();
  end
endmodule